// File: doc/BRIEF.md
# Sequential Add-and-Shift Multiplier

This block multiplies two unsigned operands by forming one partial product per clock cycle and accumulating it into a running sum. It does not build every partial product at once. A controller first captures both operands and clears the sum. It then spends one cycle on each multiplier bit, starting with the least significant. In that cycle the multiplicand is added into the upper half of the sum when the bit is set, and the sum always moves one place to the right. When every bit has been consumed, the sum holds the full double-width product.

A caller presents the operands, pulses `start` for one cycle while the block is idle, and waits for the one-cycle `done` pulse. The product stays on `product` after `done` until the next operation begins. A pulse on `start` while an operation is running is ignored. The operand width is a parameter and defaults to 4 bits, which gives an 8-bit product.

Top module: `seq_mult`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `product` is 0 and `done` is 0.
- R2: In the idle state with `start` low, `done` stays 0 and `product` keeps its value.
- R3: The cycle after `start` is accepted captures both operands and clears the running sum. Changes on `multiplicand` or `multiplier` after that cycle have no effect on the result.
- R4: Multiplier bits are used least significant first, one per step. When the bit is 1, the multiplicand is added to the upper half of the sum, and the adder's carry is kept as the new top bit.
- R5: Every step shifts the sum right by one place, whether or not an add took place.
- R6: When `done` is 1, `product` equals the unsigned product of the captured operands, for all operand pairs.
- R7: `done` is high for exactly one cycle. If `start` is sampled high in idle at clock edge k, `done` is high between edges k+OPW+1 and k+OPW+2. After that the block is idle again.
- R8: `start` is ignored while an operation is in progress, including the cycle in which `done` is high.
- R9: After `done`, `product` holds its value until a new operation clears it.
- R10: The worked case 6 x 3 gives 18 (binary 00010010), and the largest case 15 x 15 gives 225, with no loss of carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when sampled high in idle |
| multiplicand | input | OPW | Unsigned multiplicand, captured in the setup cycle |
| multiplier | input | OPW | Unsigned multiplier, captured in the setup cycle |
| product | output | 2*OPW | Running sum; holds the product once done |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The assertions assume that reset is applied before `start` is first raised, and that the operands are valid in the cycle after `start` is accepted, because the checker captures them there as its reference. The bench keeps the operands stable from the `start` pulse until `done` in normal runs. It changes them only after the setup cycle, which the design must ignore. It drives `start` only on falling clock edges, so the idle-state view of the checker matches the controller's view.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;

  typedef struct packed {
    logic mdLoad;
    logic mrLoad;
    logic sumClear;
    logic sumAdd;
    logic sumShift;
  } mult_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STEP   = 2'd2,
    ST_FINISH = 2'd3
  } mult_state_t;

endpackage

// File: rtl/seq_mult_adder.sv
module seq_mult_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  output logic [W-1:0] addSum,
  output logic         addCarry
);
  logic [W:0] carryChain;

  assign carryChain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic halfSum;
    assign halfSum         = addA[i] ^ addB[i];
    assign addSum[i]       = halfSum ^ carryChain[i];
    assign carryChain[i+1] = (addA[i] & addB[i]) | (carryChain[i] & halfSum);
  end

  assign addCarry = carryChain[W];
endmodule

// File: rtl/seq_mult_datapath.sv
module seq_mult_datapath
  import seq_mult_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mult_strobe_t         strobe,
  input  logic [OPW-1:0]       mdIn,
  input  logic [OPW-1:0]       mrIn,
  output logic                 mrBit,
  output logic [2*OPW-1:0]     sumOut
);
  localparam int PW = 2 * OPW;

  logic [OPW-1:0] mdReg;
  logic [OPW-1:0] mrReg;
  logic [PW-1:0]  sumReg;
  logic [OPW-1:0] addResult;
  logic           addCarry;
  logic [PW:0]    sumWide;

  seq_mult_adder #(.W(OPW)) u_adder (
    .addA     (sumReg[PW-1:OPW]),
    .addB     (mdReg),
    .addSum   (addResult),
    .addCarry (addCarry)
  );

  always_comb begin
    if (strobe.sumAdd) begin
      sumWide = {addCarry, addResult, sumReg[OPW-1:0]};
    end else begin
      sumWide = {1'b0, sumReg};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdReg <= '0;
    end else if (strobe.mdLoad) begin
      mdReg <= mdIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mrReg <= '0;
    end else if (strobe.mrLoad) begin
      mrReg <= mrIn;
    end else if (strobe.sumShift) begin
      mrReg <= {1'b0, mrReg[OPW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg <= '0;
    end else if (strobe.sumClear) begin
      sumReg <= '0;
    end else if (strobe.sumShift) begin
      sumReg <= sumWide[PW:1];
    end else if (strobe.sumAdd) begin
      sumReg <= sumWide[PW-1:0];
    end
  end

  assign mrBit  = mrReg[0];
  assign sumOut = sumReg;
endmodule

// File: rtl/seq_mult_control.sv
module seq_mult_control
  import seq_mult_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         mrBit,
  output mult_strobe_t strobe,
  output logic         done
);
  localparam int CNT_W = $clog2(OPW + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(OPW - 1);

  mult_state_t      state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (state == ST_SETUP) begin
      stepCnt <= '0;
    end else if (state == ST_STEP) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) stateNext = ST_SETUP;
      end
      ST_SETUP: begin
        strobe.mdLoad   = 1'b1;
        strobe.mrLoad   = 1'b1;
        strobe.sumClear = 1'b1;
        stateNext       = ST_STEP;
      end
      ST_STEP: begin
        strobe.sumAdd   = mrBit;
        strobe.sumShift = 1'b1;
        if (stepCnt == LAST_STEP) stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/seq_mult.sv
module seq_mult
  import seq_mult_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [OPW-1:0]     multiplicand,
  input  logic [OPW-1:0]     multiplier,
  output logic [2*OPW-1:0]   product,
  output logic               done
);
  mult_strobe_t strobe;
  logic         mrBit;

  seq_mult_control #(.OPW(OPW)) u_control (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .mrBit  (mrBit),
    .strobe (strobe),
    .done   (done)
  );

  seq_mult_datapath #(.OPW(OPW)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .mdIn   (multiplicand),
    .mrIn   (multiplier),
    .mrBit  (mrBit),
    .sumOut (product)
  );
endmodule

// File: rtl/seq_mult_checker.sv
module seq_mult_checker #(
  parameter int OPW = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [OPW-1:0]     multiplicand,
  input logic [OPW-1:0]     multiplier,
  input logic [2*OPW-1:0]   product,
  input logic               done
);
  localparam int PW    = 2 * OPW;
  localparam int LAT   = OPW + 1;
  localparam int CNT_W = $clog2(OPW + 3);

  logic             opBusy;
  logic [CNT_W-1:0] opCnt;
  logic [OPW-1:0]   capMd;
  logic [OPW-1:0]   capMr;
  logic [PW-1:0]    expProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opBusy <= 1'b0;
      opCnt  <= '0;
    end else if (!opBusy) begin
      opBusy <= start;
      opCnt  <= '0;
    end else if (opCnt == CNT_W'(LAT)) begin
      opBusy <= 1'b0;
    end else begin
      opCnt <= opCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capMd <= '0;
      capMr <= '0;
    end else if (opBusy && opCnt == '0) begin
      capMd <= multiplicand;
      capMr <= multiplier;
    end
  end

  assign expProd = PW'(capMd) * PW'(capMr);

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    done == (opBusy && opCnt == CNT_W'(LAT))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (opBusy && opCnt == CNT_W'(1)) |-> product == '0); // R3

  AST_PRODUCT_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> product == expProd); // R6

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!opBusy || opCnt == CNT_W'(LAT)) |=> $stable(product)); // R9
endmodule

bind seq_mult seq_mult_checker #(.OPW(OPW)) u_seq_mult_checker (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .product      (product),
  .done         (done)
);

// File: tb/seq_mult_bench.sv
module seq_mult_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OPW = 4;
  localparam int PW  = 2 * OPW;
  localparam int LAT = OPW + 1;
  localparam int NVEC = 10;

  // each entry: {multiplicand, multiplier, expected product}
  localparam logic [OPW+OPW+PW-1:0] VECTORS [NVEC] = '{
    {4'd6,  4'd3,  8'd18},
    {4'd15, 4'd15, 8'd225},
    {4'd0,  4'd9,  8'd0},
    {4'd9,  4'd0,  8'd0},
    {4'd1,  4'd1,  8'd1},
    {4'd8,  4'd8,  8'd64},
    {4'd15, 4'd1,  8'd15},
    {4'd1,  4'd15, 8'd15},
    {4'd10, 4'd5,  8'd50},
    {4'd13, 4'd11, 8'd143}
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [OPW-1:0] multiplicand = '0;
  logic [OPW-1:0] multiplier = '0;
  logic [PW-1:0]  product;
  logic           done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  seq_mult #(.OPW(OPW)) u_seq_mult (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .done         (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Runs one operation; optional disturbance mid-flight (R3, R8)
  task automatic runOp(input logic [OPW-1:0] md, input logic [OPW-1:0] mr,
                       input logic [PW-1:0] expected, input string req,
                       input bit disturb);
    int cycles;
    @(negedge clk);
    multiplicand = md;
    multiplier   = mr;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 20) begin
      @(negedge clk);
      cycles++;
      if (disturb && cycles == 1) begin
        multiplicand = ~md;
        multiplier   = ~mr;
        start        = 1'b1;
      end else if (disturb && cycles == 3) begin
        start = 1'b0;
      end
    end
    check(cycles == LAT, {req, " R7 latency"}, cycles, LAT);
    check(product == expected, {req, " R6 product"}, int'(product), int'(expected));
    if (disturb) begin
      start = 1'b1;  // R8: start while done is high must be ignored
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7 done single cycle", int'(done), 0);
    check(product == expected, "R9 product held", int'(product), int'(expected));
    multiplicand = '0;
    multiplier   = '0;
    if (disturb) begin
      repeat (LAT + 2) begin
        @(negedge clk);
        check(done == 1'b0, "R8 start during done ignored", int'(done), 0);
      end
      check(product == expected, "R8 product unchanged", int'(product), int'(expected));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(product == '0, "R1 product in reset", int'(product), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(product == '0, "R1 product after reset", int'(product), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);

    // R2: idle without start
    multiplicand = 4'd7;
    multiplier   = 4'd7;
    repeat (8) begin
      @(negedge clk);
      check(done == 1'b0 && product == '0, "R2 idle quiet", int'(product), 0);
    end

    // Table of vectors: R10 worked case and maximum first, R4/R5 patterns
    for (int i = 0; i < NVEC; i++) begin
      runOp(VECTORS[i][PW+2*OPW-1:PW+OPW], VECTORS[i][PW+OPW-1:PW],
            VECTORS[i][PW-1:0], (i < 2) ? "R10 table" : "R4 R5 table", 1'b0);
    end

    // R6: every operand pair
    for (int a = 0; a < (1 << OPW); a++) begin
      for (int b = 0; b < (1 << OPW); b++) begin
        runOp(OPW'(a), OPW'(b), PW'(a * b), "R6 sweep", 1'b0);
      end
    end

    // R3 and R8: operands change and start pulses mid-operation
    runOp(4'd11, 4'd13, 8'd143, "R3 R8 disturbed", 1'b1);
    runOp(4'd15, 4'd15, 8'd225, "R3 R8 disturbed max", 1'b1);

    // R9: product stays through idle
    repeat (6) @(negedge clk);
    check(product == 8'd225, "R9 idle hold", int'(product), 225);

    // R1: reset mid-operation returns to reset state
    @(negedge clk);
    multiplicand = 4'd9;
    multiplier   = 4'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(product == '0 && done == 1'b0, "R1 reset mid-op", int'(product), 0);
    rstN = 1'b1;
    repeat (LAT + 2) begin
      @(negedge clk);
      check(done == 1'b0, "R1 no done after reset", int'(done), 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule